// File: doc/BRIEF.md
# Balanced FIFO Multiplexer Layer

One layer of a rank-ordered packet queue. The layer holds a fixed number of parallel first-in-first-out multiplexers, each fed by a small group of input ports. In every slot any subset of the input ports may present a packet. The packet's rank or tag is computed upstream and travels as an opaque payload. Each packet is steered to whichever multiplexer currently holds the fewest packets, so the multiplexers stay level with one another.

Every multiplexer that holds a packet releases its head packet in every slot. The layer never stalls and never discards a packet. The surrounding controller reads the per-multiplexer occupancies and head packets. It must not offer more packets than the layer can hold. An assertion reports any slot in which that limit would be broken.

The number of multiplexers, the ports per multiplexer, the payload width and the per-multiplexer depth are all parameters. The default is three multiplexers with four ports each, which gives twelve inputs per slot.

Top module: `lb_layer_bank`

## Requirements
- R1: After reset every occupancy is zero, no head packet is valid, and the tie pointer selects multiplexer 0.
- R2: Every valid input packet is accepted in its slot, one packet per port, with up to NUM_MUX*MUX_PORTS packets in one slot. Every accepted packet later appears exactly once as a head packet; none is lost inside the layer.
- R3: A multiplexer may hold up to DEPTH packets. With the layer completely full, every occupancy reads DEPTH. An assertion fires if any multiplexer would exceed DEPTH.
- R4: Input packets are handled in ascending port order. Each goes to the multiplexer with the lowest running count. The running count is the occupancy after this slot's departure plus the packets already assigned earlier in the same slot. Occupancy updates on the clock edge that ends the slot.
- R5: When counts tie, the choice starts at the multiplexer named by a rotating pointer and takes the first minimum in increasing index order, wrapping around. After each assignment the pointer moves to the multiplexer after the one chosen. The pointer keeps its value across slots and does not move in a slot with no arrivals.
- R6: Packets that enter the same multiplexer in one slot leave it in input-port order, lowest port first.
- R7: At every slot the occupancies of any two multiplexers differ by at most one.
- R8: out_valid[m] is high exactly when multiplexer m holds a packet. That head packet leaves at the next clock edge, so a multiplexer never idles while it holds a packet.
- R9: out_data[m] carries the oldest packet in multiplexer m, so each multiplexer is first-in-first-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_MUX*MUX_PORTS | Per-port packet present flag |
| in_data | input | NUM_MUX*MUX_PORTS x W | Per-port packet payload (rank tag and data) |
| out_valid | output | NUM_MUX | Multiplexer holds a head packet that departs this slot |
| out_data | output | NUM_MUX x W | Head packet of each multiplexer |
| occupancy | output | NUM_MUX x clog2(DEPTH+1) | Packet count of each multiplexer |

## Verification
The bench builds the layer with three multiplexers of four ports and a depth of eight, with a 16-bit payload. The shallow depth means a few slots of full twelve-port bursts bring every multiplexer to its limit. The bench can therefore reach the completely full state and the capacity boundary often during random traffic. Each payload is a unique sequence number, so a wrong assignment, a wrong order within a multiplexer or a missing packet shows up as a mismatched head value.

// File: rtl/lb_pkg.sv
package lb_pkg;

   // Wrap a non-negative index into the range [0, n).
   function automatic int lb_mod(input int a, input int n);
      return a % n;
   endfunction

endpackage

// File: rtl/lb_assign.sv
// Per-slot assignment of input ports to the least-occupied multiplexer.
module lb_assign
   import lb_pkg::*;
#(
   parameter int NUM_MUX = 3,
   parameter int NUM_IN  = 12,
   parameter int CNT_W   = 5,
   parameter int PTR_W   = 2,
   parameter int OFF_W   = 4
)(
   input  logic [NUM_IN-1:0]             in_valid,
   input  logic [NUM_MUX-1:0][CNT_W-1:0] base_cnt,
   input  logic [PTR_W-1:0]              ptr,
   output logic [NUM_IN-1:0][PTR_W-1:0]  tgt,
   output logic [NUM_IN-1:0][OFF_W-1:0]  off,
   output logic [NUM_MUX-1:0][OFF_W-1:0] add_cnt,
   output logic [PTR_W-1:0]              ptr_nxt
);

   always_comb begin
      logic [CNT_W-1:0] run [NUM_MUX];
      logic [OFF_W-1:0] added [NUM_MUX];
      logic [PTR_W-1:0] p;
      logic [PTR_W-1:0] best;
      logic [PTR_W-1:0] idx;
      for (int m = 0; m < NUM_MUX; m++) begin
         run[m]   = base_cnt[m];
         added[m] = '0;
      end
      p    = ptr;
      best = '0;
      idx  = '0;
      tgt  = '0;
      off  = '0;
      // Ports are visited lowest first; each choice sees the earlier ones.
      for (int j = 0; j < NUM_IN; j++) begin
         if (in_valid[j]) begin
            best = p;
            for (int k = 1; k < NUM_MUX; k++) begin
               idx = PTR_W'(lb_mod(int'(p) + k, NUM_MUX));
               if (run[idx] < run[best]) best = idx;
            end
            tgt[j]      = best;
            off[j]      = added[best];
            added[best] = added[best] + OFF_W'(1);
            run[best]   = run[best] + CNT_W'(1);
            p           = PTR_W'(lb_mod(int'(best) + 1, NUM_MUX));
         end
      end
      for (int m = 0; m < NUM_MUX; m++) add_cnt[m] = added[m];
      ptr_nxt = p;
   end

endmodule

// File: rtl/lb_fifo.sv
// One multi-write, single-read FIFO multiplexer that drains its head every slot.
module lb_fifo
   import lb_pkg::*;
#(
   parameter int W      = 16,
   parameter int DEPTH  = 16,
   parameter int NUM_IN = 12,
   parameter int PTR_W  = 2,
   parameter int OFF_W  = 4,
   parameter int OCC_W  = 5,
   parameter int SUM_W  = 6,
   parameter int MUX_ID = 0
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_IN-1:0]            wr_valid,
   input  logic [NUM_IN-1:0][PTR_W-1:0] wr_tgt,
   input  logic [NUM_IN-1:0][OFF_W-1:0] wr_off,
   input  logic [NUM_IN-1:0][W-1:0]     wr_data,
   input  logic [OFF_W-1:0]             add_cnt,
   output logic                         head_valid,
   output logic [W-1:0]                 head_data,
   output logic [OCC_W-1:0]             occ
);

   localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]        mem [DEPTH];
   logic [ADDR_W-1:0]   rd_idx;
   logic [ADDR_W-1:0]   wr_idx;
   logic [SUM_W-1:0]    occ_sum;
   logic [NUM_IN-1:0][ADDR_W-1:0] slot_addr;
   logic [NUM_IN-1:0]   hit;

   assign head_valid = (occ != '0);
   assign head_data  = mem[rd_idx];
   assign occ_sum    = SUM_W'(occ) + SUM_W'(add_cnt) - SUM_W'(head_valid);

   always_comb begin
      for (int j = 0; j < NUM_IN; j++) begin
         hit[j]       = wr_valid[j] && (wr_tgt[j] == PTR_W'(MUX_ID));
         slot_addr[j] = ADDR_W'(lb_mod(int'(wr_idx) + int'(wr_off[j]), DEPTH));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_idx <= '0;
         wr_idx <= '0;
         occ    <= '0;
      end else begin
         for (int j = 0; j < NUM_IN; j++) begin
            if (hit[j]) mem[slot_addr[j]] <= wr_data[j];
         end
         if (head_valid) rd_idx <= ADDR_W'(lb_mod(int'(rd_idx) + 1, DEPTH));
         wr_idx <= ADDR_W'(lb_mod(int'(wr_idx) + int'(add_cnt), DEPTH));
         occ    <= OCC_W'(occ_sum);
      end
   end

   // R3: the slot's departure and arrivals must fit in DEPTH entries.
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      occ_sum <= SUM_W'(DEPTH));

   // R8: a non-empty multiplexer with no arrivals loses exactly its head.
   p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid && add_cnt == '0) |=> (occ == $past(occ) - 1'b1));

endmodule

// File: rtl/lb_layer_bank.sv
// A layer of balanced FIFO multiplexers fed by NUM_MUX*MUX_PORTS inputs.
module lb_layer_bank
   import lb_pkg::*;
#(
   parameter int W         = 16,
   parameter int NUM_MUX   = 3,
   parameter int MUX_PORTS = 4,
   parameter int DEPTH     = 16,
   localparam int NUM_IN   = NUM_MUX * MUX_PORTS,
   localparam int OCC_W    = $clog2(DEPTH + 1)
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_IN-1:0]             in_valid,
   input  logic [NUM_IN-1:0][W-1:0]      in_data,
   output logic [NUM_MUX-1:0]            out_valid,
   output logic [NUM_MUX-1:0][W-1:0]     out_data,
   output logic [NUM_MUX-1:0][OCC_W-1:0] occupancy
);

   localparam int SUM_W = $clog2(DEPTH + NUM_IN + 1);
   localparam int PTR_W = $clog2(NUM_MUX);
   localparam int OFF_W = $clog2(NUM_IN + 1);

   if (NUM_MUX < 2)   begin : g_bad_mux   $error("NUM_MUX must be at least 2");   end
   if (MUX_PORTS < 1) begin : g_bad_ports $error("MUX_PORTS must be at least 1"); end
   if (DEPTH < 2)     begin : g_bad_depth $error("DEPTH must be at least 2");     end
   if (W < 1)         begin : g_bad_w     $error("W must be at least 1");         end

   logic [PTR_W-1:0]              rr_ptr;
   logic [PTR_W-1:0]              ptr_nxt;
   logic [NUM_MUX-1:0][SUM_W-1:0] base_cnt;
   logic [NUM_IN-1:0][PTR_W-1:0]  tgt;
   logic [NUM_IN-1:0][OFF_W-1:0]  off;
   logic [NUM_MUX-1:0][OFF_W-1:0] add_cnt;

   // Each multiplexer's count after this slot's departure.
   for (genvar m = 0; m < NUM_MUX; m++) begin : g_base
      assign base_cnt[m] = SUM_W'(occupancy[m]) - SUM_W'(occupancy[m] != '0);
   end

   lb_assign #(
      .NUM_MUX (NUM_MUX),
      .NUM_IN  (NUM_IN),
      .CNT_W   (SUM_W),
      .PTR_W   (PTR_W),
      .OFF_W   (OFF_W)
   ) u_assign (
      .in_valid (in_valid),
      .base_cnt (base_cnt),
      .ptr      (rr_ptr),
      .tgt      (tgt),
      .off      (off),
      .add_cnt  (add_cnt),
      .ptr_nxt  (ptr_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rr_ptr <= '0;
      else        rr_ptr <= ptr_nxt;
   end

   for (genvar m = 0; m < NUM_MUX; m++) begin : g_mux
      lb_fifo #(
         .W      (W),
         .DEPTH  (DEPTH),
         .NUM_IN (NUM_IN),
         .PTR_W  (PTR_W),
         .OFF_W  (OFF_W),
         .OCC_W  (OCC_W),
         .SUM_W  (SUM_W),
         .MUX_ID (m)
      ) u_fifo (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_valid   (in_valid),
         .wr_tgt     (tgt),
         .wr_off     (off),
         .wr_data    (in_data),
         .add_cnt    (add_cnt[m]),
         .head_valid (out_valid[m]),
         .head_data  (out_data[m]),
         .occ        (occupancy[m])
      );
   end

   // Helpers for the layer-wide checks below.
   logic [OCC_W-1:0] occ_max, occ_min;
   logic [SUM_W-1:0] add_total;
   always_comb begin
      occ_max   = occupancy[0];
      occ_min   = occupancy[0];
      add_total = '0;
      for (int m = 0; m < NUM_MUX; m++) begin
         if (occupancy[m] > occ_max) occ_max = occupancy[m];
         if (occupancy[m] < occ_min) occ_min = occupancy[m];
         add_total = add_total + SUM_W'(add_cnt[m]);
      end
   end

   // R7: multiplexer occupancies stay within one of each other.
   p_balance_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_max - occ_min) <= OCC_W'(1));

   // R2: every valid input lands in exactly one multiplexer.
   p_conserve_r2: assert property (@(posedge clk) disable iff (!rst_n)
      add_total == SUM_W'($countones(in_valid)));

   // R5: the tie pointer always names an existing multiplexer.
   p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rr_ptr) < NUM_MUX);

   // R5: a slot without arrivals leaves the pointer where it was.
   p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid == '0) |=> $stable(rr_ptr));

endmodule

// File: tb/tb_lb_layer_bank.sv
module tb_lb_layer_bank;

   localparam int CLK_P     = 10;
   localparam int W         = 16;
   localparam int NUM_MUX   = 3;
   localparam int MUX_PORTS = 4;
   localparam int DEPTH     = 8;
   localparam int NUM_IN    = NUM_MUX * MUX_PORTS;
   localparam int OCC_W     = $clog2(DEPTH + 1);
   localparam int LIMIT     = 20000;

   logic                          clk = 1'b0;
   logic                          rst_n = 1'b0;
   logic [NUM_IN-1:0]             in_valid = '0;
   logic [NUM_IN-1:0][W-1:0]      in_data = '0;
   logic [NUM_MUX-1:0]            out_valid;
   logic [NUM_MUX-1:0][W-1:0]     out_data;
   logic [NUM_MUX-1:0][OCC_W-1:0] occupancy;

   lb_layer_bank #(.W(W), .NUM_MUX(NUM_MUX), .MUX_PORTS(MUX_PORTS), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data), .occupancy(occupancy));

   always #(CLK_P/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   int mocc [NUM_MUX];
   logic [W-1:0] mdat [NUM_MUX][DEPTH];
   int mptr = 0;
   int sent = 0;
   int emitted = 0;
   logic [W-1:0] tag = '0;
   bit done = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int model_total();
      int t = 0;
      for (int m = 0; m < NUM_MUX; m++) t += mocc[m];
      return t;
   endfunction

   // Expected next state from the requirements: departures, then port-order assignment.
   task automatic model_apply(input logic [NUM_IN-1:0] v, input logic [NUM_IN-1:0][W-1:0] d);
      for (int m = 0; m < NUM_MUX; m++) begin
         if (mocc[m] > 0) begin
            for (int k = 0; k < DEPTH-1; k++) mdat[m][k] = mdat[m][k+1];
            mocc[m]--;
         end
      end
      for (int j = 0; j < NUM_IN; j++) begin
         if (v[j]) begin
            int best = mptr;
            for (int k = 1; k < NUM_MUX; k++) begin
               int idx = (mptr + k) % NUM_MUX;
               if (mocc[idx] < mocc[best]) best = idx;
            end
            if (mocc[best] < DEPTH) mdat[best][mocc[best]] = d[j];
            mocc[best]++;
            mptr = (best + 1) % NUM_MUX;
         end
      end
   endtask

   task automatic check_outputs();
      int mx = 0, mn = DEPTH + 1;
      for (int m = 0; m < NUM_MUX; m++) begin
         check(int'(occupancy[m]) == mocc[m], "R4 occupancy", int'(occupancy[m]), mocc[m]);
         check(out_valid[m] == (mocc[m] != 0), "R8 head valid", int'(out_valid[m]), int'(mocc[m] != 0));
         if (mocc[m] != 0)
            check(out_data[m] == mdat[m][0], "R9 head data", int'(out_data[m]), int'(mdat[m][0]));
         if (int'(occupancy[m]) > mx) mx = int'(occupancy[m]);
         if (int'(occupancy[m]) < mn) mn = int'(occupancy[m]);
         if (out_valid[m]) emitted++;
      end
      check(mx - mn <= 1, "R7 balance", mx - mn, 1);
   endtask

   // Drive one slot at the falling edge, then check at the next falling edge.
   task automatic step(input logic [NUM_IN-1:0] v);
      logic [NUM_IN-1:0][W-1:0] d;
      for (int j = 0; j < NUM_IN; j++) begin
         d[j] = tag;
         if (v[j]) begin
            tag++;
            sent++;
         end
      end
      in_valid = v;
      in_data  = d;
      model_apply(v, d);
      @(negedge clk);
      in_valid = '0;
      check_outputs();
   endtask

   function automatic logic [NUM_IN-1:0] trim(input logic [NUM_IN-1:0] v);
      int room = NUM_MUX * DEPTH;
      for (int m = 0; m < NUM_MUX; m++) room -= (mocc[m] > 0) ? mocc[m] - 1 : 0;
      for (int j = NUM_IN - 1; j >= 0; j--)
         if ($countones(v) > room) v[j] = 1'b0;
      return v;
   endfunction

   initial begin
      #(CLK_P * LIMIT);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed = 32'h1d5c;
      logic [W-1:0] t0;
      void'($urandom(seed));
      for (int m = 0; m < NUM_MUX; m++) mocc[m] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state.
      for (int m = 0; m < NUM_MUX; m++)
         check(occupancy[m] == '0 && !out_valid[m], "R1 reset", int'(occupancy[m]), 0);

      // R5: single arrivals into an empty layer rotate 0,1,2,0,... from pointer 0.
      for (int s = 0; s < 6; s++) begin
         step(NUM_IN'(1));
         check(out_valid == NUM_MUX'(1 << (s % NUM_MUX)), "R5 rotation",
               int'(out_valid), 1 << (s % NUM_MUX));
      end
      step('0);

      // R6: ports 0..3 from empty with pointer 0: mux0 gets port0 then port3.
      t0 = tag;
      step(NUM_IN'(4'hf));
      check(out_data[0] == t0, "R6 port order first", int'(out_data[0]), int'(t0));
      step('0);
      check(out_data[0] == t0 + 3, "R6 port order second", int'(out_data[0]), int'(t0) + 3);
      repeat (2) step('0);

      // R3: full bursts until every multiplexer reaches DEPTH.
      repeat (5) step(trim('1));
      for (int m = 0; m < NUM_MUX; m++)
         check(int'(occupancy[m]) == DEPTH, "R3 full", int'(occupancy[m]), DEPTH);
      repeat (DEPTH + 2) step('0);

      // Random traffic with varying density.
      for (int i = 0; i < 3000; i++) begin
         logic [NUM_IN-1:0] v;
         int dens = (i / 500) % 4;
         for (int j = 0; j < NUM_IN; j++) v[j] = (($urandom % 4) < dens);
         step(trim(v));
      end

      // R2: drain and confirm every packet left exactly once.
      repeat (DEPTH + 2) step('0);
      check(model_total() == 0, "R2 drained", model_total(), 0);
      check(emitted == sent, "R2 conservation", emitted, sent);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule